// File: doc/BRIEF.md
# Fractional-N Injection Phase Selector

This block picks, once per reference clock cycle, which of 28 oscillator phase taps receives the next injection pulse. An injection-locked ring oscillator whose injected edge moves by a non-integer number of taps per reference cycle produces a fractional-N output frequency. The block has two control inputs. The first is a sub-integer step word giving the whole number of taps to advance. The second is a 16-bit fractional word, which a first-order delta-sigma accumulator turns into a dithered extra tap step.

The advance moves a phase pointer held modulo 28. The pointer is decoded into a one-hot select vector. That vector is registered on the reference clock and frozen while the injection pulse is high, so a tap enable never changes during a pulse. Each of the 28 gate lines is the NAND of its select bit and the shared injection pulse, so the gate lines are active low. The analog oscillator, interpolation and pulse shaping lie outside the block, and the pulse arrives as a digital input.

Top module: `frac_inj_sel`

## Requirements
- R1: While rst_ni is low, and directly after it rises, ptr_o is 0 and sel_o is all zeros. All 28 gate_no lines are high whatever the level of inj_pulse_i.
- R2: A 16-bit accumulator adds frac_i on every rising clock edge, wrapping modulo 2^16. The carry for that edge is 1 exactly when the old accumulator value plus frac_i reaches 2^16 or more.
- R3: On every rising edge ptr_o becomes (ptr_o + step_i + carry) mod 28, so ptr_o always stays in the range 0 to 27.
- R4: A step_i value from 28 to 31 advances the pointer by the same amount as step_i minus 28.
- R5: When inj_pulse_i is low at a rising edge, sel_o loads a one-hot vector. Its only set bit is bit k, where k is the value ptr_o held before that edge. Bit k enables tap k.
- R6: When inj_pulse_i is high at a rising edge, sel_o keeps its value, even if ptr_o moves.
- R7: gate_no[i] is the NAND of sel_o[i] and inj_pulse_i, with no register in between. At most one gate line is low at any time, and all lines are high while the pulse is low.
- R8: Over a long run with constant inputs, the mean pointer advance per cycle equals step_i + frac_i/65536, with an accumulated error of at most one tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 5 | Whole taps to advance per cycle (legal 0 to 27) |
| frac_i | input | 16 | Fractional advance in units of 1/65536 tap |
| inj_pulse_i | input | 1 | Shared injection pulse |
| ptr_o | output | 5 | Current phase pointer |
| sel_o | output | 28 | Registered one-hot tap select |
| gate_no | output | 28 | Per-tap gated injection, active low |

## Verification
The hardest case to reach is a pointer move that falls inside an injection pulse. Here the select vector must hold its old tap while the pointer advances underneath it, and then jump straight to the latest pointer once the pulse drops. The bench holds the pulse high over several edges with a nonzero step and dither. It then releases the pulse and checks each cycle's select and gate lines against its own model of the accumulator and pointer. The average-rate case uses a quarter-tap fraction over 400 cycles, so the dither carry fires many times, and sums the observed pointer advances.

// File: rtl/frac_inj_sel_pkg.sv
package frac_inj_sel_pkg;
  localparam int unsigned NUM_TAPS = 28;
  localparam int unsigned FRAC_W   = 16;
  localparam int unsigned PTR_W    = $clog2(NUM_TAPS);
  localparam int unsigned STEP_W   = PTR_W;
  typedef logic [PTR_W-1:0]    ptr_t;
  typedef logic [NUM_TAPS-1:0] tap_vec_t;
endpackage

// File: rtl/fis_dsm.sv
module fis_dsm #(
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fis_phase_ptr.sv
module fis_phase_ptr #(
  parameter int unsigned NUM_TAPS = 28,
  parameter int unsigned PTR_W    = $clog2(NUM_TAPS),
  parameter int unsigned STEP_W   = PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  input  logic              carry_i,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int unsigned SUM_W = ((PTR_W > STEP_W) ? PTR_W : STEP_W) + 2;
  localparam logic [SUM_W-1:0] N1 = SUM_W'(NUM_TAPS);
  localparam logic [SUM_W-1:0] N2 = SUM_W'(2 * NUM_TAPS);

  logic [PTR_W-1:0] ptr_q;
  logic [SUM_W-1:0] sum, wrapped;

  assign sum = SUM_W'(ptr_q) + SUM_W'(step_i) + SUM_W'(carry_i);

  // ptr < N and step < 2^STEP_W <= 2N, so two compares suffice
  always_comb begin
    if (sum >= N2)      wrapped = sum - N2;
    else if (sum >= N1) wrapped = sum - N1;
    else                wrapped = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= wrapped[PTR_W-1:0];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/fis_sel_retime.sv
module fis_sel_retime #(
  parameter int unsigned NUM_TAPS = 28,
  parameter int unsigned PTR_W    = $clog2(NUM_TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic                pulse_i,
  output logic [NUM_TAPS-1:0] sel_o
);
  logic [NUM_TAPS-1:0] dec, sel_q;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_dec
    assign dec[i] = (ptr_i == PTR_W'(i));
  end

  // freeze the enables while a pulse is in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (!pulse_i) sel_q <= dec;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/fis_gate_array.sv
module fis_gate_array #(
  parameter int unsigned NUM_TAPS = 28
) (
  input  logic [NUM_TAPS-1:0] sel_i,
  input  logic                pulse_i,
  output logic [NUM_TAPS-1:0] gate_no
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_nand
    assign gate_no[i] = ~(sel_i[i] & pulse_i);
  end
endmodule

// File: rtl/frac_inj_sel.sv
module frac_inj_sel
  import frac_inj_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              inj_pulse_i,
  output ptr_t              ptr_o,
  output tap_vec_t          sel_o,
  output tap_vec_t          gate_no
);
  logic carry;

  fis_dsm #(.FRAC_W(FRAC_W)) i_dsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frac_i  (frac_i),
    .carry_o (carry)
  );

  fis_phase_ptr #(.NUM_TAPS(NUM_TAPS), .PTR_W(PTR_W), .STEP_W(STEP_W)) i_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .carry_i (carry),
    .ptr_o   (ptr_o)
  );

  fis_sel_retime #(.NUM_TAPS(NUM_TAPS), .PTR_W(PTR_W)) i_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ptr_i   (ptr_o),
    .pulse_i (inj_pulse_i),
    .sel_o   (sel_o)
  );

  fis_gate_array #(.NUM_TAPS(NUM_TAPS)) i_gate (
    .sel_i   (sel_o),
    .pulse_i (inj_pulse_i),
    .gate_no (gate_no)
  );
endmodule

// File: rtl/frac_inj_sel_chk.sv
module frac_inj_sel_chk
  import frac_inj_sel_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STEP_W-1:0] step_i,
  input logic [FRAC_W-1:0] frac_i,
  input logic              inj_pulse_i,
  input ptr_t              ptr_o,
  input tap_vec_t          sel_o,
  input tap_vec_t          gate_no
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_ptr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_o) < NUM_TAPS);

  p_ptr_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> (int'(ptr_o) == (int'($past(ptr_o)) + int'($past(step_i)) % NUM_TAPS) % NUM_TAPS) ||
                (int'(ptr_o) == (int'($past(ptr_o)) + int'($past(step_i)) % NUM_TAPS + 1) % NUM_TAPS));

  p_sel_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !inj_pulse_i) |=> (sel_o == (tap_vec_t'(1) << $past(ptr_o))));

  p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_pulse_i |=> $stable(sel_o));

  p_one_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~gate_no) <= 1);

  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_pulse_i |-> (&gate_no));

  p_sel_onehot0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
endmodule

bind frac_inj_sel frac_inj_sel_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .frac_i      (frac_i),
  .inj_pulse_i (inj_pulse_i),
  .ptr_o       (ptr_o),
  .sel_o       (sel_o),
  .gate_no     (gate_no)
);

// File: tb/test_frac_inj_sel.sv
module test_frac_inj_sel;
  localparam int N = 28;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  step_i = '0;
  logic [15:0] frac_i = '0;
  logic        inj_pulse_i = 1'b0;
  logic [4:0]  ptr_o;
  logic [27:0] sel_o, gate_no;

  int n_cmp = 0, n_bad = 0;
  int unsigned acc_m = 0;
  int ptr_m = 0;
  logic [27:0] sel_m = '0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  frac_inj_sel i_frac_inj_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .frac_i(frac_i),
    .inj_pulse_i(inj_pulse_i), .ptr_o(ptr_o), .sel_o(sel_o), .gate_no(gate_no)
  );

  task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [27:0] g_exp;
    g_exp = ~(sel_m & {28{inj_pulse_i}});
    check({tag, " R3 ptr"}, ptr_o == 5'(ptr_m), 32'(ptr_o), 32'(ptr_m));
    check({tag, " R5/R6 sel"}, sel_o == sel_m, 32'(sel_o), 32'(sel_m));
    check({tag, " R7 gate"}, gate_no == g_exp, 32'(gate_no), 32'(g_exp));
  endtask

  // one reference edge, model updated from the requirements
  task automatic tick();
    bit p;
    int pb, carry;
    p = inj_pulse_i;
    pb = ptr_m;
    @(posedge clk_i);
    acc_m = acc_m + int'(frac_i);
    carry = (acc_m >= 65536) ? 1 : 0;   // R2
    acc_m = acc_m % 65536;
    ptr_m = (ptr_m + int'(step_i) % N + carry) % N;
    if (!p) sel_m = 28'(1) << pb;
    #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    inj_pulse_i = 1'b1;
    step_i = 5'd7;
    frac_i = 16'hFFFF;
    repeat (3) @(posedge clk_i);
    #1;
    acc_m = 0; ptr_m = 0; sel_m = '0;
    check("R1 ptr in reset", ptr_o == 0, 32'(ptr_o), 0);
    check("R1 sel in reset", sel_o == 0, 32'(sel_o), 0);
    check("R1 gates high with pulse", &gate_no, 32'(gate_no), 32'hFFFFFFF);
    @(negedge clk_i);
    rst_ni = 1'b1;
    inj_pulse_i = 1'b0;
    step_i = '0;
    frac_i = '0;
    #1;
    check("R1 ptr after release", ptr_o == 0, 32'(ptr_o), 0);
    check("R1 sel after release", sel_o == 0, 32'(sel_o), 0);
  endtask

  task automatic t_integer();
    step_i = 5'd5; frac_i = 16'd0; inj_pulse_i = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(); check_all("integer R3 R5"); end
  endtask

  task automatic t_wrap();
    step_i = 5'd27; frac_i = 16'hC000;
    for (int i = 0; i < 16; i++) begin tick(); check_all("wrap R2 R3"); end
  endtask

  task automatic t_illegal();
    step_i = 5'd30; frac_i = 16'd0;
    for (int i = 0; i < 8; i++) begin tick(); check_all("R4 step30"); end
    step_i = 5'd28;
    for (int i = 0; i < 4; i++) begin tick(); check_all("R4 step28"); end
  endtask

  task automatic t_hold();
    logic [27:0] held;
    step_i = 5'd4; frac_i = 16'h9000;
    tick();
    held = sel_o;
    inj_pulse_i = 1'b1;
    #1;
    check_all("R7 pulse rise");
    check("R7 one line low", $countones(~gate_no) == 1, 32'($countones(~gate_no)), 1);
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R6 sel held", sel_o == held, 32'(sel_o), 32'(held));
      check_all("R6 hold");
    end
    inj_pulse_i = 1'b0;
    #1;
    check("R7 idle all high", &gate_no, 32'(gate_no), 32'hFFFFFFF);
    tick();
    check_all("R5 release reload");
  endtask

  task automatic t_gating();
    step_i = 5'd9; frac_i = 16'h1234;
    for (int i = 0; i < 20; i++) begin
      inj_pulse_i = i[0];
      #1;
      check_all("R7 truth");
      tick();
      check_all("R5 R6 toggle");
    end
    inj_pulse_i = 1'b0;
  endtask

  task automatic t_average();
    int prev, total;
    step_i = 5'd3; frac_i = 16'h4000; inj_pulse_i = 1'b0;
    total = 0;
    prev = int'(ptr_o);
    for (int i = 0; i < 400; i++) begin
      tick();
      total += (int'(ptr_o) - prev + N) % N;
      prev = int'(ptr_o);
    end
    check("R8 mean advance", (total >= 1299) && (total <= 1301), 32'(total), 32'd1300);
    step_i = 5'd0; frac_i = 16'h8000;
    total = 0;
    prev = int'(ptr_o);
    for (int i = 0; i < 200; i++) begin
      tick();
      total += (int'(ptr_o) - prev + N) % N;
      prev = int'(ptr_o);
    end
    check("R8 half tap", (total >= 99) && (total <= 101), 32'(total), 32'd100);
    check_all("R2 after average");
  endtask

  initial begin
    t_reset();
    t_integer();
    t_wrap();
    t_illegal();
    t_hold();
    t_gating();
    t_average();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule